// File: doc/BRIEF.md
# Adaptive Line Zero-Crossing Period Detector

This block watches a stream of rectified line-voltage samples and works out where each zero crossing of the line falls, so that a downstream RMS accumulator knows where one half cycle ends and the next begins. A sample counts only on a cycle where the sample-valid input is high. The block compares each sample against an adaptive threshold with programmable hysteresis. It notes the sample index at which the waveform drops below the threshold band and the index at which it climbs back above it. It places the zero crossing exactly halfway between the two. The distance between two successive zero crossings is the half-line period. This period is reported as a 16-bit sample count, together with a one-cycle strobe that marks the half-cycle boundary.

The threshold follows the signal amplitude. It is one eighth of the largest sample seen in the window between the two most recent boundaries. When the input carries no crossings, as with a DC supply, a timeout falls back to a programmed maximum period. In that case a boundary is strobed every maximum-period samples until the line locks again.

Top module: `lzc_period_det`

## Requirements
- R1: While reset is asserted and right after it is released, `per_stb` is 0, `per_val` is 0 and `dc_act` is 1 (the block starts in fallback mode).
- R2: From the below state, a rising event occurs on a valid sample with `smp >= thr + hyst`. From the above state, a falling event occurs on a valid sample with `smp + hyst < thr`. Samples inside the band leave the state unchanged. The block starts in the below state.
- R3: `thr` equals the tracked peak shifted right by 3 bits. The peak starts at 1024 (giving `thr` = 128). At every boundary the peak is reloaded with the maximum of all valid samples since the previous boundary, including the boundary sample itself.
- R4: A rising event that follows at least one falling event is a zero-crossing event. Its crossing index is `f + floor((r - f) / 2)`, where `f` is the index of the latest falling event and `r` is the index of the rising sample.
- R5: In normal mode, each zero-crossing event raises `per_stb` for one cycle on the clock edge that follows its sample. `per_val` then holds the difference, modulo 2^16, between this crossing index and the previous one. No other strobe occurs in normal mode.
- R6: Only cycles with `smp_vld` high advance the sample index and the timeout count. Idle cycles change no result, and a strobe only follows a valid sample.
- R7: When `max_per` valid samples have passed since the last boundary without a zero-crossing event, the block strobes with `per_val = max_per`, sets `dc_act`, and counts this as a boundary.
- R8: In fallback mode, the first zero-crossing event produces no strobe and leaves `dc_act` at 1. The second one produces a normal period strobe and clears `dc_act`. A timeout in between restarts this two-crossing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | High on cycles that carry a sample |
| smp | input | 12 | Rectified line-voltage sample, unsigned |
| hyst | input | 8 | Hysteresis half-width in LSBs |
| max_per | input | 16 | Fallback period in samples |
| per_stb | output | 1 | One-cycle half-cycle boundary strobe |
| per_val | output | 16 | Half-period in samples, valid with `per_stb` |
| dc_act | output | 1 | High while the fallback period is in use |

## Verification
A wrong sample index or a wrong stored falling index shows up as a `per_val` that is off by a few counts on the very next strobe. This shows most clearly with uneven low intervals, where the floor-halved midpoint terms no longer cancel. A stale or mis-scaled threshold, or missing hysteresis, either adds strobes within one half cycle or drops a crossing. A dropped crossing appears as a timeout strobe carrying `max_per` about `max_per` samples later. A broken lock counter shows at once as `dc_act` staying high, or falling too early, around the crossing after a timeout.

// File: rtl/lzc_pkg.sv
`timescale 1ns/1ps
package lzc_pkg;
  localparam int unsigned LZC_DW    = 12;
  localparam int unsigned LZC_PW    = 16;
  localparam int unsigned LZC_HW    = 8;
  localparam int unsigned LZC_SHIFT = 3;
  localparam int unsigned LZC_PEAK0 = 1024;

  // crossing index halfway between falling index f and rising index r (modular in pw bits)
  function automatic int unsigned lzc_mid(int unsigned f, int unsigned r, int unsigned pw);
    int unsigned mask;
    mask = (32'd1 << pw) - 32'd1;
    return (f + (((r - f) & mask) >> 1)) & mask;
  endfunction

  // threshold derived from a tracked peak
  function automatic int unsigned lzc_thr(int unsigned pk, int unsigned shift);
    return pk >> shift;
  endfunction
endpackage

// File: rtl/lzc_peak.sv
`timescale 1ns/1ps
module lzc_peak
  import lzc_pkg::*;
#(
  parameter int unsigned DW        = LZC_DW,
  parameter int unsigned SHIFT     = LZC_SHIFT,
  parameter int unsigned INIT_PEAK = LZC_PEAK0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [DW-1:0] smp,
  input  logic          bnd,
  output logic [DW-1:0] thr
);
  logic [DW-1:0] pk;
  logic [DW-1:0] run_pk;
  logic [DW-1:0] nx_pk;

  assign nx_pk = (smp > run_pk) ? smp : run_pk;
  assign thr   = DW'(lzc_thr(32'(pk), SHIFT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk     <= DW'(INIT_PEAK);
      run_pk <= '0;
    end else if (vld) begin
      if (bnd) begin
        pk     <= nx_pk;
        run_pk <= '0;
      end else begin
        run_pk <= nx_pk;
      end
    end
  end
endmodule

// File: rtl/lzc_cross.sv
`timescale 1ns/1ps
module lzc_cross #(
  parameter int unsigned DW = 12,
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] thr,
  input  logic [HW-1:0] hyst,
  output logic          rise_ev,
  output logic          fall_ev
);
  localparam int unsigned EW = DW + 1;

  logic          above;
  logic [EW-1:0] up_lvl;
  logic [EW-1:0] smp_up;

  assign up_lvl  = {1'b0, thr} + EW'(hyst);
  assign smp_up  = {1'b0, smp} + EW'(hyst);
  assign rise_ev = vld && !above && ({1'b0, smp} >= up_lvl);
  assign fall_ev = vld && above && (smp_up < {1'b0, thr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       above <= 1'b0;
    else if (rise_ev) above <= 1'b1;
    else if (fall_ev) above <= 1'b0;
  end
endmodule

// File: rtl/lzc_track.sv
`timescale 1ns/1ps
module lzc_track
  import lzc_pkg::*;
#(
  parameter int unsigned PW = LZC_PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          rise_ev,
  input  logic          fall_ev,
  input  logic [PW-1:0] max_per,
  output logic          zc_ev,
  output logic          tmo_ev,
  output logic          bnd,
  output logic          per_stb,
  output logic [PW-1:0] per_val,
  output logic          dc_act
);
  logic [PW-1:0] idx;
  logic [PW-1:0] fall_idx;
  logic [PW-1:0] zc_prev;
  logic [PW-1:0] run;
  logic [PW-1:0] zc_now;
  logic          have_fall;
  logic          seen;

  assign zc_now = PW'(lzc_mid(32'(fall_idx), 32'(idx), PW));
  assign zc_ev  = rise_ev && have_fall;
  assign tmo_ev = vld && !zc_ev && (({1'b0, run} + (PW+1)'(1)) >= {1'b0, max_per});
  assign bnd    = zc_ev || tmo_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      fall_idx  <= '0;
      zc_prev   <= '0;
      run       <= '0;
      have_fall <= 1'b0;
      seen      <= 1'b0;
      dc_act    <= 1'b1;
      per_stb   <= 1'b0;
      per_val   <= '0;
    end else begin
      per_stb <= 1'b0;
      if (vld) begin
        idx <= idx + PW'(1);
        if (fall_ev) begin
          fall_idx  <= idx;
          have_fall <= 1'b1;
        end
        if (zc_ev) begin
          zc_prev <= zc_now;
          run     <= '0;
          if (!dc_act) begin
            per_stb <= 1'b1;
            per_val <= zc_now - zc_prev;
          end else if (seen) begin
            per_stb <= 1'b1;
            per_val <= zc_now - zc_prev;
            dc_act  <= 1'b0;
            seen    <= 1'b0;
          end else begin
            seen <= 1'b1;
          end
        end else if (tmo_ev) begin
          run     <= '0;
          per_stb <= 1'b1;
          per_val <= max_per;
          dc_act  <= 1'b1;
          seen    <= 1'b0;
        end else begin
          run <= run + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lzc_period_det.sv
`timescale 1ns/1ps
module lzc_period_det
  import lzc_pkg::*;
#(
  parameter int unsigned DW        = LZC_DW,
  parameter int unsigned PW        = LZC_PW,
  parameter int unsigned HW        = LZC_HW,
  parameter int unsigned SHIFT     = LZC_SHIFT,
  parameter int unsigned INIT_PEAK = LZC_PEAK0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp,
  input  logic [HW-1:0] hyst,
  input  logic [PW-1:0] max_per,
  output logic          per_stb,
  output logic [PW-1:0] per_val,
  output logic          dc_act
);
  logic [DW-1:0] thr;
  logic          rise_ev;
  logic          fall_ev;
  logic          zc_ev;
  logic          tmo_ev;
  logic          bnd;

  lzc_peak #(.DW(DW), .SHIFT(SHIFT), .INIT_PEAK(INIT_PEAK)) u_peak (
    .clk(clk), .rst_n(rst_n), .vld(smp_vld), .smp(smp), .bnd(bnd), .thr(thr)
  );

  lzc_cross #(.DW(DW), .HW(HW)) u_cross (
    .clk(clk), .rst_n(rst_n), .vld(smp_vld), .smp(smp), .thr(thr), .hyst(hyst),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  lzc_track #(.PW(PW)) u_track (
    .clk(clk), .rst_n(rst_n), .vld(smp_vld), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .max_per(max_per), .zc_ev(zc_ev), .tmo_ev(tmo_ev), .bnd(bnd),
    .per_stb(per_stb), .per_val(per_val), .dc_act(dc_act)
  );
endmodule

// File: rtl/lzc_chk.sv
`timescale 1ns/1ps
module lzc_chk #(
  parameter int unsigned PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic [PW-1:0] max_per,
  input logic          per_stb,
  input logic [PW-1:0] per_val,
  input logic          dc_act,
  input logic          zc_ev,
  input logic          tmo_ev
);
  a_r6_stb_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |-> $past(smp_vld));

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |-> $past(zc_ev || tmo_ev));

  a_r5_zc_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_ev && !dc_act) |=> per_stb);

  a_r7_timeout_val: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_ev |=> (per_stb && dc_act && per_val == $past(max_per)));

  a_r8_exit_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dc_act) |-> per_stb);
endmodule

bind lzc_period_det lzc_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .max_per(max_per),
  .per_stb(per_stb), .per_val(per_val), .dc_act(dc_act),
  .zc_ev(zc_ev), .tmo_ev(tmo_ev)
);

// File: tb/sim_lzc_period_det.sv
`timescale 1ns/1ps
module sim_lzc_period_det;
  localparam int DW = 12;
  localparam int PW = 16;
  localparam int HW = 8;

  typedef struct {
    int    val;
    int    gap;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vld;
  logic [DW-1:0] smp;
  logic [HW-1:0] hyst;
  logic [PW-1:0] maxp;
  logic          per_stb;
  logic [PW-1:0] per_val;
  logic          dc_act;

  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  int   last_stb = 0;
  int   last_L = 0;
  int   last_H = 0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lzc_period_det u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(vld), .smp(smp), .hyst(hyst), .max_per(maxp),
    .per_stb(per_stb), .per_val(per_val), .dc_act(dc_act)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic put(input int v, input int g, input string tag);
    exp_t e;
    e.val = v; e.gap = g; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic smp1(input int v, input bit gap);
    @(negedge clk);
    smp = DW'(v);
    vld = 1'b1;
    if (gap) begin
      @(negedge clk);
      vld = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      vld = 1'b0;
    end
  endtask

  // one low interval followed by one high interval; expected period from segment lengths
  task automatic cyc_t(input int ln, input int lv, input int hn, input int hv,
                       input bit noisy, input bit gap, input bit push, input int ndc,
                       input string tag);
    if (push) put(last_L + last_H + (ln >> 1) - (last_L >> 1), 0, tag);
    for (int k = 0; k < ndc; k++) put(int'(maxp), int'(maxp), "R7 fallback period");
    for (int i = 0; i < ln; i++) smp1((noisy && (i % 2 == 1)) ? 110 : lv, gap);
    for (int i = 0; i < hn; i++) smp1((noisy && (i % 2 == 1)) ? 90 : hv, gap);
    last_L = ln;
    last_H = hn;
  endtask

  task automatic peek_dc(input bit e, input string tag);
    @(negedge clk);
    vld = 1'b0;
    chk(dc_act == e, tag, int'(dc_act), int'(e));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && per_stb === 1'b1) begin
      if (q.size() == 0) begin
        chk(1'b0, "R5 strobe with nothing expected", int'(per_val), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(per_val) == e.val, e.tag, int'(per_val), e.val);
        if (e.gap > 0) chk((cyc - last_stb) == e.gap, "R7 fallback strobe spacing", cyc - last_stb, e.gap);
      end
      last_stb = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; vld = 1'b0; smp = '0; hyst = 8'd16; maxp = 16'd64;
    repeat (3) @(negedge clk);
    chk(per_stb == 1'b0, "R1 strobe low in reset", int'(per_stb), 0);
    chk(per_val == '0, "R1 period zero in reset", int'(per_val), 0);
    chk(dc_act == 1'b1, "R1 fallback active in reset", int'(dc_act), 1);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    chk(dc_act == 1'b1 && per_stb == 1'b0, "R1 state after release", int'(dc_act), 1);

    // start-up lock: high first, then two crossings
    for (int i = 0; i < 30; i++) smp1(800, 1'b0);
    cyc_t(10, 0, 30, 800, 0, 0, 0, 0, "R8 first crossing");
    peek_dc(1'b1, "R8 one crossing keeps fallback");
    cyc_t(10, 0, 30, 800, 0, 0, 1, 0, "R8 second crossing period");
    peek_dc(1'b0, "R8 fallback cleared after second crossing");

    cyc_t(12, 0, 30, 800, 1, 0, 1, 0, "R2 hysteresis band ignores noise");
    cyc_t(7, 0, 25, 800, 1, 0, 1, 0, "R4 odd low interval midpoint");
    cyc_t(15, 0, 25, 800, 0, 1, 1, 0, "R6 idle cycles not counted");
    cyc_t(4, 0, 40, 800, 0, 0, 1, 0, "R4 short low interval midpoint");

    // adaptive threshold
    cyc_t(10, 0, 30, 2000, 0, 0, 1, 0, "R5 period before amplitude step");
    cyc_t(10, 150, 30, 2000, 0, 0, 1, 0, "R3 raised threshold sees 150 as low");
    cyc_t(10, 0, 30, 800, 0, 0, 1, 0, "R3 period with held peak");
    cyc_t(10, 0, 30, 800, 0, 0, 1, 0, "R3 threshold follows smaller peak");

    // DC hold: timeouts, then relock
    cyc_t(10, 0, 140, 800, 0, 0, 1, 2, "R5 period before hold");
    peek_dc(1'b1, "R7 fallback entered on timeout");
    cyc_t(10, 0, 20, 800, 0, 0, 0, 0, "R8 relock first crossing");
    peek_dc(1'b1, "R8 one crossing after timeout keeps fallback");
    cyc_t(10, 0, 20, 800, 0, 0, 1, 0, "R8 relock period");
    peek_dc(1'b0, "R8 fallback cleared after relock");

    idle(20);
    chk(q.size() == 0, "R5 every expected strobe seen", q.size(), 0);
    summary();
    $finish;
  end
endmodule